// File: doc/BRIEF.md
# Display Controller Write-Only I2C Target

This block is the serial front end of a character display controller. It watches the two I2C lines, which are synchronised into the system clock domain, and finds START and STOP conditions. It takes in the first byte of each transfer and acknowledges it only when that byte carries the fixed 7-bit address 0x3E with the write direction bit.

After the address, the block reads each byte as either a control byte or a payload byte. In a control byte, bit 7 is a continuation flag and bit 6 selects the register.

- When the continuation flag is set, exactly one payload byte follows, and then another control byte.
- When the continuation flag is clear, every byte up to the end of the transfer is payload with the same register select.

Each payload byte leaves the block as a single-cycle write strobe, with the byte value and a flag that marks it as RAM data (1) or an instruction (0), for a downstream instruction executor. The block never returns data. It only pulls SDA low during acknowledge slots.

Top module: `lcd_i2c_wr_slave`

## Requirements
- R1: A write to address 0x3E (first byte 0x7C) is acknowledged by sda_oe being high during the ninth SCL high phase.
- R2: A first byte that carries any other address is not acknowledged. No payload strobe and no acknowledge follow until the next START.
- R3: A first byte with the direction bit (bit 0) set to 1 gets no acknowledge and produces no strobe, even when it carries address 0x3E.
- R4: A control byte with bit 7 = 1 is followed by exactly one payload byte. The byte after that is treated as a new control byte.
- R5: After a control byte with bit 7 = 0, every remaining byte up to STOP or a repeated START is payload with that control byte's bit 6.
- R6: wr_rs equals bit 6 of the governing control byte: 1 marks RAM data and 0 marks an instruction. wr_data equals the payload byte, received MSB first.
- R7: In an addressed transfer, every control byte and every payload byte is acknowledged. sda_oe rises and falls only while SCL is low.
- R8: A repeated START or a STOP ends the current transfer. After a repeated START the next byte is treated as an address and the byte after it as a control byte.
- R9: Each payload byte produces wr_strobe high for exactly one clock cycle. Control and address bytes produce no strobe.
- R10: After reset, wr_strobe, wr_rs, wr_data and sda_oe are all zero, and bytes sent without a preceding START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| wr_strobe | output | 1 | One-cycle pulse per payload byte |
| wr_data | output | 8 | Payload byte value |
| wr_rs | output | 1 | 1 = RAM data, 0 = instruction |

## Verification
The checker assumes that SCL stays at each level for several system clocks. This lets the synchronised edges and the pad signal agree on whether SCL is low when sda_oe changes. It also means payload bytes are far enough apart that two strobes never fall in adjacent cycles.

The bench keeps to these assumptions by holding every SCL phase for ten clocks or more. It changes SDA only in the middle of the SCL low phase, except where it deliberately forms a START or STOP.

It models the open-drain line as a wired AND of the master's drive and the block's pull-down, so acknowledges are read from the shared line.

// File: rtl/lcd_i2c_pkg.sv
package lcd_i2c_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      PS_CTRL   = 2'd0,
      PS_SINGLE = 2'd1,
      PS_STREAM = 2'd2
   } parse_st_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_q, sda_q;
   logic scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
         scl_q    <= scl_pipe[SYNC_STAGES-1];
         sda_q    <= sda_pipe[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[SYNC_STAGES-1];
   assign sda_s     = sda_pipe[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
   import lcd_i2c_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h3E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   output logic              sda_oe,
   output logic              byte_stb,
   output logic [BYTE_W-1:0] byte_val,
   output logic              addressed
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
   localparam logic [BYTE_W-1:0] WR_MATCH = {SLAVE_ADDR, 1'b0};

   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] next_byte;
   logic [CNT_W-1:0]  cnt;
   logic              first_byte;
   logic              ack_req;
   logic              ack_phase;

   assign next_byte = {shreg[BYTE_W-2:0], sda_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         cnt        <= '0;
         first_byte <= 1'b0;
         addressed  <= 1'b0;
         ack_req    <= 1'b0;
         ack_phase  <= 1'b0;
         sda_oe     <= 1'b0;
         byte_stb   <= 1'b0;
         byte_val   <= '0;
      end else begin
         byte_stb <= 1'b0;
         if (start_det) begin
            cnt        <= '0;
            first_byte <= 1'b1;
            addressed  <= 1'b0;
            ack_req    <= 1'b0;
            ack_phase  <= 1'b0;
            sda_oe     <= 1'b0;
         end else if (stop_det) begin
            cnt        <= '0;
            first_byte <= 1'b0;
            addressed  <= 1'b0;
            ack_req    <= 1'b0;
            ack_phase  <= 1'b0;
            sda_oe     <= 1'b0;
         end else begin
            if (scl_rise && (cnt < ACK_SLOT) && (first_byte || addressed)) begin
               shreg <= next_byte;
               cnt   <= cnt + 1'b1;
               if (cnt == LAST_BIT) begin
                  if (first_byte) begin
                     first_byte <= 1'b0;
                     addressed  <= (next_byte == WR_MATCH);
                     ack_req    <= (next_byte == WR_MATCH);
                  end else begin
                     byte_stb <= 1'b1;
                     byte_val <= next_byte;
                     ack_req  <= 1'b1;
                  end
               end
            end
            if (scl_fall && (cnt == ACK_SLOT)) begin
               if (!ack_phase) begin
                  ack_phase <= 1'b1;
                  sda_oe    <= ack_req;
               end else begin
                  ack_phase <= 1'b0;
                  sda_oe    <= 1'b0;
                  cnt       <= '0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ctl_byte_parser.sv
module ctl_byte_parser
   import lcd_i2c_pkg::*;
#(
   parameter int CONT_BIT = 7,
   parameter int SEL_BIT  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_reset,
   input  logic              byte_stb,
   input  logic [BYTE_W-1:0] byte_val,
   output logic              wr_strobe,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_rs
);
   parse_st_t st;
   logic      rs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= PS_CTRL;
         rs_q      <= 1'b0;
         wr_strobe <= 1'b0;
         wr_data   <= '0;
         wr_rs     <= 1'b0;
      end else begin
         wr_strobe <= 1'b0;
         if (frame_reset) begin
            st <= PS_CTRL;
         end else if (byte_stb) begin
            case (st)
               PS_CTRL: begin
                  rs_q <= byte_val[SEL_BIT];
                  st   <= byte_val[CONT_BIT] ? PS_SINGLE : PS_STREAM;
               end
               PS_SINGLE: begin
                  wr_strobe <= 1'b1;
                  wr_data   <= byte_val;
                  wr_rs     <= rs_q;
                  st        <= PS_CTRL;
               end
               PS_STREAM: begin
                  wr_strobe <= 1'b1;
                  wr_data   <= byte_val;
                  wr_rs     <= rs_q;
               end
               default: st <= PS_CTRL;
            endcase
         end
      end
   end
endmodule

// File: rtl/lcd_i2c_wr_slave.sv
module lcd_i2c_wr_slave
   import lcd_i2c_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR  = 7'h3E,
   parameter int         SYNC_STAGES = 2,
   parameter int         CONT_BIT    = 7,
   parameter int         SEL_BIT     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              wr_strobe,
   output logic [BYTE_W-1:0] wr_data,
   output logic              wr_rs
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((CONT_BIT >= BYTE_W) || (SEL_BIT >= BYTE_W) || (CONT_BIT == SEL_BIT)) begin : g_bad_bits
         $error("control bit positions must be distinct and inside the byte");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              byte_stb, addressed;
   logic [BYTE_W-1:0] byte_val;

   i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_byte_rx #(.SLAVE_ADDR(SLAVE_ADDR)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_oe    (sda_oe),
      .byte_stb  (byte_stb),
      .byte_val  (byte_val),
      .addressed (addressed)
   );

   ctl_byte_parser #(.CONT_BIT(CONT_BIT), .SEL_BIT(SEL_BIT)) u_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_reset (start_det | stop_det),
      .byte_stb    (byte_stb),
      .byte_val    (byte_val),
      .wr_strobe   (wr_strobe),
      .wr_data     (wr_data),
      .wr_rs       (wr_rs)
   );
endmodule

// File: rtl/lcd_i2c_wr_slave_chk.sv
module lcd_i2c_wr_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic sda_oe,
   input logic wr_strobe,
   input logic start_det,
   input logic stop_det,
   input logic addressed
);
   // R9: a payload strobe never lasts two cycles
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe);

   // R7: acknowledge drive starts only while SCL is low
   p_oe_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_in);

   // R7: acknowledge drive ends only while SCL is low
   p_oe_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> !scl_in);

   // R2: a strobe only comes from an addressed transfer
   p_strobe_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> $past(addressed));

   // R8: STOP ends the addressed state
   p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !addressed);

   // R8: a (repeated) START drops back to address matching
   p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !addressed);
endmodule

bind lcd_i2c_wr_slave lcd_i2c_wr_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_in    (scl_in),
   .sda_oe    (sda_oe),
   .wr_strobe (wr_strobe),
   .start_det (start_det),
   .stop_det  (stop_det),
   .addressed (addressed)
);

// File: tb/sim_lcd_i2c_wr_slave.sv
`timescale 1ns/1ps
module sim_lcd_i2c_wr_slave;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe, wr_strobe, wr_rs;
   logic [7:0] wr_data;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   logic [7:0] cap_d [32];
   logic       cap_r [32];
   int         cap_n = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   lcd_i2c_wr_slave u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl),
      .sda_in    (sda_line),
      .sda_oe    (sda_oe),
      .wr_strobe (wr_strobe),
      .wr_data   (wr_data),
      .wr_rs     (wr_rs)
   );

   always @(negedge clk) begin
      if (wr_strobe && cap_n < 32) begin
         cap_d[cap_n] = wr_data;
         cap_r[cap_n] = wr_rs;
         cap_n = cap_n + 1;
      end
   end

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold(5);
      scl = 1'b1;   hold(10);
      sda_m = 1'b0; hold(10);
      scl = 1'b0;   hold(5);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold(5);
      scl = 1'b1;   hold(10);
      sda_m = 1'b1; hold(10);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hold(5);
         scl = 1'b1;   hold(10);
         scl = 1'b0;   hold(5);
      end
      sda_m = 1'b1; hold(5);
      scl = 1'b1;   hold(5);
      ack = ~sda_line;
      hold(5);
      scl = 1'b0;   hold(5);
   endtask

   task automatic expect_evt(input int idx, input logic [7:0] d, input logic rs, input string req);
      check(cap_d[idx] == d, req, int'(cap_d[idx]), int'(d));
      check(cap_r[idx] == rs, req, int'(cap_r[idx]), int'(rs));
   endtask

   task automatic t_reset();
      hold(3);
      check(wr_strobe == 1'b0, "R10 strobe", int'(wr_strobe), 0);
      check(sda_oe == 1'b0, "R10 sda_oe", int'(sda_oe), 0);
      check(wr_data == 8'h00 && wr_rs == 1'b0, "R10 data/rs", int'({wr_rs, wr_data}), 0);
   endtask

   task automatic t_no_start();
      bit a;
      cap_n = 0;
      send_byte(8'h7C, a);
      check(a == 1'b0, "R10 ack without START", int'(a), 0);
      send_byte(8'h00, a);
      send_byte(8'h55, a);
      hold(10);
      check(cap_n == 0, "R10 strobes without START", cap_n, 0);
   endtask

   task automatic t_stream_data();
      bit a;
      cap_n = 0;
      bus_start();
      send_byte(8'h7C, a); check(a, "R1 address ack", int'(a), 1);
      send_byte(8'h40, a); check(a, "R7 control ack", int'(a), 1);
      send_byte(8'h48, a); check(a, "R7 payload ack", int'(a), 1);
      send_byte(8'hC0, a); check(a, "R5 payload with bit7 set ack", int'(a), 1);
      send_byte(8'h01, a);
      bus_stop();
      hold(10);
      check(cap_n == 3, "R5 stream count", cap_n, 3);
      expect_evt(0, 8'h48, 1'b1, "R5 R6 first");
      expect_evt(1, 8'hC0, 1'b1, "R5 control-looking payload");
      expect_evt(2, 8'h01, 1'b1, "R5 R6 third");
   endtask

   task automatic t_pairs();
      bit a;
      cap_n = 0;
      bus_start();
      send_byte(8'h7C, a);
      send_byte(8'h80, a);
      send_byte(8'h38, a);
      send_byte(8'hC0, a);
      send_byte(8'h41, a);
      send_byte(8'h00, a); check(a, "R7 last control ack", int'(a), 1);
      send_byte(8'h0C, a);
      send_byte(8'h01, a);
      bus_stop();
      hold(10);
      check(cap_n == 4, "R4 pair count", cap_n, 4);
      expect_evt(0, 8'h38, 1'b0, "R4 R6 instruction");
      expect_evt(1, 8'h41, 1'b1, "R4 R6 ram data");
      expect_evt(2, 8'h0C, 1'b0, "R5 instruction stream");
      expect_evt(3, 8'h01, 1'b0, "R5 instruction stream");
   endtask

   task automatic t_wrong_addr();
      bit a;
      cap_n = 0;
      bus_start();
      send_byte(8'h7E, a); check(a == 1'b0, "R2 wrong address nack", int'(a), 0);
      send_byte(8'h40, a); check(a == 1'b0, "R2 later byte nack", int'(a), 0);
      send_byte(8'h33, a);
      hold(10);
      check(cap_n == 0, "R2 no strobe", cap_n, 0);
      bus_start();
      send_byte(8'h7C, a); check(a, "R2 R8 recovery after START", int'(a), 1);
      send_byte(8'h40, a);
      send_byte(8'h5A, a);
      bus_stop();
      hold(10);
      check(cap_n == 1, "R2 recovery count", cap_n, 1);
      expect_evt(0, 8'h5A, 1'b1, "R2 recovery data");
   endtask

   task automatic t_read_bit();
      bit a;
      cap_n = 0;
      bus_start();
      send_byte(8'h7D, a); check(a == 1'b0, "R3 read nack", int'(a), 0);
      send_byte(8'h40, a); check(a == 1'b0, "R3 no ack after read", int'(a), 0);
      send_byte(8'h12, a);
      bus_stop();
      hold(10);
      check(cap_n == 0, "R3 no strobe", cap_n, 0);
   endtask

   task automatic t_restart();
      bit a;
      cap_n = 0;
      bus_start();
      send_byte(8'h7C, a);
      send_byte(8'h40, a);
      send_byte(8'h11, a);
      bus_start();
      send_byte(8'h7C, a); check(a, "R8 address after repeated START", int'(a), 1);
      send_byte(8'h22, a);
      send_byte(8'h33, a);
      bus_stop();
      hold(10);
      check(cap_n == 2, "R8 restart count", cap_n, 2);
      expect_evt(0, 8'h11, 1'b1, "R8 before restart");
      expect_evt(1, 8'h33, 1'b0, "R8 control re-expected");
   endtask

   task automatic t_pulse();
      bit a;
      int hi = 0;
      bus_start();
      send_byte(8'h7C, a);
      send_byte(8'h40, a); check(a, "R9 control ack", int'(a), 1);
      fork
         begin
            send_byte(8'h77, a);
         end
         begin
            repeat (200) begin
               @(negedge clk);
               if (wr_strobe) hi++;
            end
         end
      join
      bus_stop();
      check(hi == 1, "R9 strobe width", hi, 1);
   endtask

   initial begin
      hold(4);
      rst_n = 1'b1;
      t_reset();
      t_no_start();
      t_stream_data();
      t_pairs();
      t_wrong_addr();
      t_read_bit();
      t_restart();
      t_pulse();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule